// File: doc/BRIEF.md
# Oversampled UART Receive Path

This block receives a fixed 8N1 serial stream, oversampling the line at 14 ticks per bit. Each tick comes from a prescaler that counts a programmable 8-bit rate value. Completed characters go into a 64-entry receive FIFO. Each entry carries a framing-error tag and a break tag alongside the data byte. Software uses a small register port to pop characters, read the fill count, set up the trigger threshold, the inactivity timeout and the interrupt enables, and read or clear the status flags.

The register port is word indexed by `addr_i`:

| Index | Register | Access |
|---|---|---|
| 0 | FIFO read | A read with `rd_en_i` high pops one entry. |
| 1 | Level | Read only. |
| 2 | Status | A write clears the latched flags. |
| 3 | Control | Read and write. |
| 4 | Rate | Read and write. |

Reads are combinational on `rdata_o`. A write takes effect on the next clock edge. The interrupt line is the OR of the status bits that the control register enables.

Top module: `fast_uart_rx`

## Requirements
- R1: After reset:
  - the rate register reads 0xFF and the control register reads 0;
  - the level reads 0 and the status reads 0;
  - a FIFO read returns 0x100;
  - `irq_o` is low.
- R2: One bit lasts (rate+1)*14 clocks. A frame is one low start bit, 8 data bits LSB first, and one stop bit. A correctly received byte is stored with both tags clear.
- R3: A FIFO read word carries:
  - the byte in bits [7:0];
  - bit 8 set when the FIFO was empty, in which case nothing is popped;
  - bit 9 as the framing-error tag;
  - bit 10 as the break tag.
  Entries pop in arrival order.
- R4: The level register (index 1) reports the FIFO count in bits [7:0].
- R5: A low stop bit with nonzero data stores the byte with tag bit 9 and latches status bit 3.
- R6: A low stop bit with all data bits zero is a break. It stores a zero byte with tag bit 10 and latches status bit 4. The receiver then waits for the line to go high before it looks for a new start bit.
- R7: The FIFO holds 64 entries. A character that completes while the FIFO is full is discarded and latches status bit 5.
- R8: Writing 1 to status bit 3, 4 or 5 clears that bit. Written 0 bits leave their flags unchanged.
- R9: Control bits [4:2] select the receive threshold: code 0 is 1, 1 is 4, 2 is 8, 3 is 16, 4 is 32, and codes 5 to 7 are 48. Status bit 1 is high while the count is at or above the threshold.
- R10: Control bits [17:16] select the inactivity timeout: 0 is off, 1 is 4, 2 is 8, 3 is 16 character times, with one character time being 140*(rate+1) clocks.
  - Status bit 2 sets once the receiver has been idle that long with data pending.
  - A push, a pop or an empty FIFO clears it.
- R11: `irq_o` = (control bit 6 AND (status bit 1 OR status bit 2)) OR (control bit 7 AND (status bit 3 OR 4 OR 5)).
- R12: A low pulse shorter than half a bit is rejected and stores nothing. Start and data bits are decided by a majority of three samples around mid-bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rx_i | input | 1 | Serial receive line, idle high |
| addr_i | input | 3 | Register word index |
| wr_en_i | input | 1 | Register write strobe |
| rd_en_i | input | 1 | Register read strobe (pops at index 0) |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, combinational on addr_i |
| irq_o | output | 1 | Interrupt request |

## Verification
The bench drives the line with:
- clean frames of distinct byte values, which separate bit order and period errors;
- frames with a low stop bit and nonzero data, against all-zero data, which separate the framing-error and break classifications;
- a short low glitch, which shows whether start validation works;
- a burst of 65 frames, which exposes the full boundary and discard behaviour;
- a slower rate value, which confirms the prescaler scaling.

A behavioural model holds a queue and the flags. It is compared against the level and the interrupt line on every quiet clock.

// File: rtl/fur_pkg.sv
package fur_pkg;
  localparam int DATA_BITS = 8;
  localparam int TICKS_PER_BIT = 14;
  localparam int BITS_PER_CHAR = 10;

  localparam logic [2:0] ADDR_FIFO  = 3'd0;
  localparam logic [2:0] ADDR_LEVEL = 3'd1;
  localparam logic [2:0] ADDR_STAT  = 3'd2;
  localparam logic [2:0] ADDR_CTRL  = 3'd3;
  localparam logic [2:0] ADDR_RATE  = 3'd4;

  localparam logic [31:0] CTRL_MASK = 32'h0003_00DC;

  typedef struct packed {
    logic                 brk;
    logic                 fe;
    logic [DATA_BITS-1:0] data;
  } rx_word_t;

  typedef enum logic [2:0] {
    RX_IDLE, RX_START, RX_DATA, RX_STOP, RX_HOLD
  } rx_state_e;
endpackage

// File: rtl/fur_rx_engine.sv
module fur_rx_engine
  import fur_pkg::*;
#(
  parameter int TPB = TICKS_PER_BIT
) (
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     rx_i,
  input  logic     tick_i,
  output logic     push_o,
  output rx_word_t word_o,
  output logic     idle_o
);
  localparam int TW  = $clog2(TPB);
  localparam int MID = TPB / 2;
  localparam int BW  = $clog2(DATA_BITS);

  rx_state_e            state_q;
  logic [1:0]           sync_q;
  logic [TW-1:0]        tcnt_q;
  logic [BW-1:0]        bcnt_q;
  logic [1:0]           smp_q;
  logic [DATA_BITS-1:0] shreg_q;
  logic                 rx_s, vote;

  assign rx_s   = sync_q[1];
  assign vote   = (smp_q[0] & smp_q[1]) | (smp_q[0] & rx_s) | (smp_q[1] & rx_s);
  assign idle_o = (state_q == RX_IDLE);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= RX_IDLE;
      sync_q  <= 2'b11;
      tcnt_q  <= '0;
      bcnt_q  <= '0;
      smp_q   <= 2'b11;
      shreg_q <= '0;
      push_o  <= 1'b0;
      word_o  <= '0;
    end else begin
      push_o <= 1'b0;
      sync_q <= {sync_q[0], rx_i};
      if (tick_i) begin
        unique case (state_q)
          RX_IDLE: if (!rx_s) begin
            state_q <= RX_START;
            tcnt_q  <= TW'(1);
          end
          RX_HOLD: if (rx_s) state_q <= RX_IDLE;
          default: begin
            if (tcnt_q == TW'(MID - 1)) smp_q[0] <= rx_s;
            if (tcnt_q == TW'(MID))     smp_q[1] <= rx_s;
            if (tcnt_q == TW'(MID + 1)) begin
              unique case (state_q)
                RX_START: if (vote) state_q <= RX_IDLE;
                RX_DATA:  shreg_q <= {vote, shreg_q[DATA_BITS-1:1]};
                RX_STOP: begin
                  push_o <= 1'b1;
                  if (vote) begin
                    word_o  <= '{brk: 1'b0, fe: 1'b0, data: shreg_q};
                    state_q <= RX_IDLE;
                  end else if (shreg_q == '0) begin
                    word_o  <= '{brk: 1'b1, fe: 1'b0, data: '0};
                    state_q <= RX_HOLD;
                  end else begin
                    word_o  <= '{brk: 1'b0, fe: 1'b1, data: shreg_q};
                    state_q <= RX_HOLD;
                  end
                end
                default: ;
              endcase
            end
            if (tcnt_q == TW'(TPB - 1)) begin
              tcnt_q <= '0;
              if (state_q == RX_START) begin
                state_q <= RX_DATA;
                bcnt_q  <= '0;
              end else if (state_q == RX_DATA) begin
                if (bcnt_q == BW'(DATA_BITS - 1)) state_q <= RX_STOP;
                else bcnt_q <= bcnt_q + 1'b1;
              end
            end else begin
              tcnt_q <= tcnt_q + 1'b1;
            end
          end
        endcase
      end
    end
  end

  AST_PUSH_SPACING: assert property (@(posedge clk_i) disable iff (!rst_ni)
    push_o |=> !push_o); // R2
  AST_BRK_WAITS_HIGH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (push_o && word_o.brk) |-> (state_q == RX_HOLD)); // R6
endmodule

// File: rtl/fur_fifo.sv
module fur_fifo #(
  parameter int DEPTH = 64,
  parameter int WIDTH = 10,
  localparam int AW = $clog2(DEPTH),
  localparam int CW = AW + 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             push_i,
  input  logic             pop_i,
  input  logic [WIDTH-1:0] din_i,
  output logic [WIDTH-1:0] dout_o,
  output logic [CW-1:0]    count_o,
  output logic             full_o,
  output logic             empty_o
);
  logic [WIDTH-1:0] mem_q [DEPTH];
  logic [AW-1:0]    wp_q, rp_q;
  logic             do_push, do_pop;

  assign full_o  = (count_o == CW'(DEPTH));
  assign empty_o = (count_o == '0);
  assign do_push = push_i && !full_o;
  assign do_pop  = pop_i && !empty_o;
  assign dout_o  = mem_q[rp_q];

  always_ff @(posedge clk_i) begin
    if (do_push) mem_q[wp_q] <= din_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wp_q    <= '0;
      rp_q    <= '0;
      count_o <= '0;
    end else begin
      if (do_push) wp_q <= (wp_q == AW'(DEPTH - 1)) ? '0 : wp_q + 1'b1;
      if (do_pop)  rp_q <= (rp_q == AW'(DEPTH - 1)) ? '0 : rp_q + 1'b1;
      unique case ({do_push, do_pop})
        2'b10:   count_o <= count_o + 1'b1;
        2'b01:   count_o <= count_o - 1'b1;
        default: ;
      endcase
    end
  end

  AST_NO_OVERFLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (full_o && push_i && !pop_i) |=> (count_o == CW'(DEPTH))); // R7
  AST_COUNT_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    count_o <= CW'(DEPTH)); // R7
  AST_EMPTY_POP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (empty_o && pop_i && !push_i) |=> empty_o); // R3
endmodule

// File: rtl/fur_timeout.sv
module fur_timeout
  import fur_pkg::*;
#(
  parameter int TPB = TICKS_PER_BIT,
  parameter int BPC = BITS_PER_CHAR,
  localparam int CHAR_TICKS = TPB * BPC,
  localparam int MAX_TICKS = 16 * CHAR_TICKS,
  localparam int CW = $clog2(MAX_TICKS + 1)
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       tick_i,
  input  logic [1:0] sel_i,
  input  logic       pending_i,
  input  logic       idle_i,
  input  logic       clr_i,
  output logic       to_o
);
  logic [CW-1:0] cnt_q, limit;

  always_comb begin
    unique case (sel_i)
      2'd1:    limit = CW'(4 * CHAR_TICKS);
      2'd2:    limit = CW'(8 * CHAR_TICKS);
      default: limit = CW'(16 * CHAR_TICKS);
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      to_o  <= 1'b0;
    end else if (sel_i == 2'd0 || !pending_i || clr_i) begin
      cnt_q <= '0;
      to_o  <= 1'b0;
    end else if (!idle_i) begin
      cnt_q <= '0;
    end else if (tick_i && !to_o) begin
      if (cnt_q == limit - 1'b1) to_o <= 1'b1;
      else cnt_q <= cnt_q + 1'b1;
    end
  end

  AST_TO_NEEDS_DATA: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(to_o) |-> $past(pending_i)); // R10
  AST_TO_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> !to_o); // R10
endmodule

// File: rtl/fast_uart_rx.sv
module fast_uart_rx
  import fur_pkg::*;
#(
  parameter int DEPTH = 64,
  parameter int TPB = TICKS_PER_BIT,
  localparam int WW = $bits(rx_word_t),
  localparam int CW = $clog2(DEPTH) + 1
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        rx_i,
  input  logic [2:0]  addr_i,
  input  logic        wr_en_i,
  input  logic        rd_en_i,
  input  logic [31:0] wdata_i,
  output logic [31:0] rdata_o,
  output logic        irq_o
);
  logic [7:0]  rate_q, pcnt_q;
  logic [31:0] ctrl_q;
  logic        st_fe_q, st_brk_q, st_ovr_q;
  logic        tick, eng_push, eng_idle, pop, trig, to_flag;
  rx_word_t    eng_word, head;
  logic [WW-1:0] head_raw;
  logic [CW-1:0] count;
  logic        full, empty;
  logic [6:0]  thr;
  logic [5:0]  status;

  assign tick = (pcnt_q >= rate_q);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pcnt_q <= '0;
    else pcnt_q <= tick ? '0 : pcnt_q + 1'b1;
  end

  fur_rx_engine #(.TPB(TPB)) u_engine (
    .clk_i, .rst_ni, .rx_i, .tick_i(tick),
    .push_o(eng_push), .word_o(eng_word), .idle_o(eng_idle)
  );

  assign pop = rd_en_i && (addr_i == ADDR_FIFO) && !empty;

  fur_fifo #(.DEPTH(DEPTH), .WIDTH(WW)) u_fifo (
    .clk_i, .rst_ni, .push_i(eng_push), .pop_i(pop), .din_i(eng_word),
    .dout_o(head_raw), .count_o(count), .full_o(full), .empty_o(empty)
  );
  assign head = rx_word_t'(head_raw);

  fur_timeout #(.TPB(TPB)) u_timeout (
    .clk_i, .rst_ni, .tick_i(tick), .sel_i(ctrl_q[17:16]),
    .pending_i(!empty), .idle_i(eng_idle), .clr_i(eng_push || pop),
    .to_o(to_flag)
  );

  always_comb begin
    unique case (ctrl_q[4:2])
      3'd0:    thr = 7'd1;
      3'd1:    thr = 7'd4;
      3'd2:    thr = 7'd8;
      3'd3:    thr = 7'd16;
      3'd4:    thr = 7'd32;
      default: thr = 7'd48;
    endcase
  end
  assign trig   = (7'(count) >= thr);
  assign status = {st_ovr_q, st_brk_q, st_fe_q, to_flag, trig, 1'b0};
  assign irq_o  = (ctrl_q[6] && (trig || to_flag)) ||
                  (ctrl_q[7] && (st_fe_q || st_brk_q || st_ovr_q));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rate_q   <= 8'hFF;
      ctrl_q   <= '0;
      st_fe_q  <= 1'b0;
      st_brk_q <= 1'b0;
      st_ovr_q <= 1'b0;
    end else begin
      if (wr_en_i && addr_i == ADDR_RATE) rate_q <= wdata_i[7:0];
      if (wr_en_i && addr_i == ADDR_CTRL) ctrl_q <= wdata_i & CTRL_MASK;
      if (wr_en_i && addr_i == ADDR_STAT) begin
        if (wdata_i[3]) st_fe_q  <= 1'b0;
        if (wdata_i[4]) st_brk_q <= 1'b0;
        if (wdata_i[5]) st_ovr_q <= 1'b0;
      end
      if (eng_push && eng_word.fe)  st_fe_q  <= 1'b1;
      if (eng_push && eng_word.brk) st_brk_q <= 1'b1;
      if (eng_push && full)         st_ovr_q <= 1'b1;
    end
  end

  always_comb begin
    unique case (addr_i)
      ADDR_FIFO:  rdata_o = empty ? 32'h100 : {21'd0, head.brk, head.fe, 1'b0, head.data};
      ADDR_LEVEL: rdata_o = 32'(count);
      ADDR_STAT:  rdata_o = {26'd0, status};
      ADDR_CTRL:  rdata_o = ctrl_q;
      ADDR_RATE:  rdata_o = {24'd0, rate_q};
      default:    rdata_o = '0;
    endcase
  end

  AST_OVR_LATCH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (eng_push && full) |=> st_ovr_q); // R7
  AST_W1C_FE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && addr_i == ADDR_STAT && wdata_i[3] && !(eng_push && eng_word.fe)) |=> !st_fe_q); // R8
  AST_FE_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_fe_q && !(wr_en_i && addr_i == ADDR_STAT)) |=> st_fe_q); // R5
  AST_LEVEL_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (addr_i == ADDR_LEVEL) |-> (rdata_o <= 32'(DEPTH))); // R4
endmodule

// File: tb/tb_fast_uart_rx.sv
module tb_fast_uart_rx;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0, rst_n = 1'b0, rx = 1'b1;
  logic [2:0]  addr = 3'd1;
  logic        wr_en = 1'b0, rd_en = 1'b0;
  logic [31:0] wdata = '0, rdata;
  logic        irq;

  int checks = 0, fails = 0;
  int rate = 255;
  int q[$];
  bit m_fe, m_brk, m_ovr, m_to;
  int m_ctrl = 0;
  bit live = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  fast_uart_rx dut (
    .clk_i(clk), .rst_ni(rst_n), .rx_i(rx), .addr_i(addr), .wr_en_i(wr_en),
    .rd_en_i(rd_en), .wdata_i(wdata), .rdata_o(rdata), .irq_o(irq)
  );

  function automatic int thr_of(int code);
    case (code)
      0: return 1; 1: return 4; 2: return 8; 3: return 16; 4: return 32;
      default: return 48;
    endcase
  endfunction

  function automatic bit m_irq();
    bit t = (q.size() >= thr_of((m_ctrl >> 2) & 7));
    return ((m_ctrl >> 6) & 1) && (t || m_to) || ((m_ctrl >> 7) & 1) && (m_fe || m_brk || m_ovr);
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  // Compare level and irq with the model on every quiet clock
  always @(negedge clk) begin
    if (live && addr == 3'd1 && !wr_en && !rd_en) begin
      chk("R4 level", int'(rdata), q.size());
      chk("R11 irq", int'(irq), int'(m_irq()));
    end
  end

  task automatic reg_wr(input int a, input int d);
    live = 0;
    @(negedge clk); addr = 3'(a); wdata = d; wr_en = 1'b1;
    @(negedge clk); wr_en = 1'b0; addr = 3'd1;
    if (a == 3) m_ctrl = d & 32'h0003_00DC;
    if (a == 4) rate = d & 255;
    if (a == 2) begin
      if (d & 8) m_fe = 0;
      if (d & 16) m_brk = 0;
      if (d & 32) m_ovr = 0;
    end
    live = 1;
  endtask

  task automatic reg_rd(input int a, output int v);
    live = 0;
    @(negedge clk); addr = 3'(a); rd_en = 1'b1; #1 v = int'(rdata);
    @(negedge clk); rd_en = 1'b0; addr = 3'd1;
    if (a == 0 && q.size() > 0) begin void'(q.pop_front()); m_to = 0; end
    live = 1;
  endtask

  task automatic send(input int d, input bit stop);
    int nb = (rate + 1) * 14;
    live = 0;
    @(negedge clk); rx = 1'b0;
    repeat (nb) @(negedge clk);
    for (int i = 0; i < 8; i++) begin
      rx = d[i];
      repeat (nb) @(negedge clk);
    end
    rx = stop;
    repeat (nb) @(negedge clk);
    rx = 1'b1;
    repeat (nb) @(negedge clk);
    m_to = 0;
    if (!stop && d == 0) begin
      m_brk = 1;
      if (q.size() < 64) q.push_back(32'h400); else m_ovr = 1;
    end else begin
      if (!stop) m_fe = 1;
      if (q.size() < 64) q.push_back((stop ? 0 : 32'h200) | d); else m_ovr = 1;
    end
    live = 1;
  endtask

  task automatic drain();
    int v;
    while (q.size() > 0) begin
      int e = q[0];
      reg_rd(0, v);
      chk("R3 drain word", v, e);
    end
  endtask

  initial begin
    int v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    reg_rd(4, v); chk("R1 rate", v, 255);
    reg_rd(3, v); chk("R1 ctrl", v, 0);
    reg_rd(2, v); chk("R1 status", v, 0);
    reg_rd(0, v); chk("R1 R3 empty read", v, 32'h100);
    chk("R1 irq", int'(irq), 0);

    // R2 R3 plain frames at rate 0
    reg_wr(4, 0);
    send(8'hA5, 1); send(8'h3C, 1);
    reg_rd(1, v); chk("R4 level two", v, 2);
    reg_rd(0, v); chk("R2 first byte", v, 32'hA5);
    reg_rd(0, v); chk("R3 order", v, 32'h3C);
    reg_rd(0, v); chk("R3 empty tag", v, 32'h100);

    // R5 framing error, R8 write-one-clear
    reg_wr(3, 32'h80);
    send(8'h5A, 0);
    reg_rd(2, v); chk("R5 fe latched", v & 8, 8);
    chk("R11 err irq", int'(irq), 1);
    reg_rd(0, v); chk("R5 fe tag", v, 32'h25A);
    reg_wr(2, 32'h10);
    reg_rd(2, v); chk("R8 zero bit keeps fe", v & 8, 8);
    reg_wr(2, 32'h08);
    reg_rd(2, v); chk("R8 fe cleared", v & 8, 0);

    // R6 break
    send(8'h00, 0);
    reg_rd(0, v); chk("R6 break word", v, 32'h400);
    reg_rd(2, v); chk("R6 brk latched", v & 16, 16);
    reg_wr(2, 32'h38);
    reg_wr(3, 0);

    // R12 glitch rejection
    live = 0;
    @(negedge clk); rx = 1'b0; repeat (4) @(negedge clk); rx = 1'b1;
    repeat (300) @(negedge clk);
    live = 1;
    reg_rd(1, v); chk("R12 glitch ignored", v, 0);

    // R9 threshold 4 with rx interrupt
    reg_wr(3, (1 << 2) | (1 << 6));
    send(1, 1); send(2, 1); send(3, 1);
    reg_rd(2, v); chk("R9 below thr", v & 2, 0);
    chk("R11 irq below", int'(irq), 0);
    send(4, 1);
    reg_rd(2, v); chk("R9 at thr", v & 2, 2);
    chk("R11 irq at thr", int'(irq), 1);
    drain();

    // R10 timeout of 4 chars, threshold 48
    reg_wr(3, (1 << 16) | (5 << 2) | (1 << 6));
    send(8'h77, 1);
    live = 0;
    repeat (500) @(negedge clk);
    chk("R10 no early timeout", int'(rdata[7:0]), 1);
    addr = 3'd2; #1 chk("R10 not yet", int'(rdata & 4), 0);
    repeat (100) @(negedge clk);
    #1 chk("R10 timeout set", int'(rdata & 4), 4);
    addr = 3'd1;
    m_to = 1;
    live = 1;
    @(negedge clk);
    chk("R11 timeout irq", int'(irq), 1);
    reg_rd(0, v); chk("R10 data", v, 32'h77);
    reg_rd(2, v); chk("R10 cleared by read", v & 4, 0);
    reg_wr(3, 0);

    // R7 overrun
    for (int i = 0; i < 65; i++) send(i + 1, 1);
    reg_rd(1, v); chk("R7 full level", v, 64);
    reg_rd(2, v); chk("R7 ovr latched", v & 32, 32);
    for (int i = 0; i < 63; i++) reg_rd(0, v);
    reg_rd(0, v); chk("R7 last kept", v, 64);
    reg_rd(0, v); chk("R7 discarded", v, 32'h100);
    reg_wr(2, 32'h20);
    reg_rd(2, v); chk("R8 ovr cleared", v & 32, 0);

    // R2 slower rate
    reg_wr(4, 2);
    send(8'hC3, 1);
    reg_rd(0, v); chk("R2 rate 2 byte", v, 32'hC3);

    live = 0;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    checks++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule